// File: doc/BRIEF.md
# Carry-Save Multi-Operand Adder

This block adds a parameterized number of operands into one result word in a single combinational pass. Each operand may be added or subtracted, and each may be treated as signed or unsigned. Every operand is widened to the result width first: zero fill for unsigned operands, copies of its top active bit for signed ones. A subtracted operand enters the reduction bitwise inverted. The missing +1 for every inverted operand is gathered into one correction word, and that word joins the reduction as one more vector.

The reduction is a set of 3:2 full-adder rows. Each row takes three vectors and returns a sum vector and a carry vector shifted up one bit, with the top carry dropped. The rows are fed in queue order, so independent rows sit at the same logic level. A single carry-propagate adder combines the last two vectors, so V input vectors use exactly V-2 rows. A parameter can remove subtraction support. The correction vector then disappears, and a two-operand instance reduces to one plain adder with no rows.

A parameter mask can mark operand slots as narrow. Such a slot uses only its low `NARROW_W` bits, and its sign is taken from bit `NARROW_W-1`.

Top module: `csa_tree_adder`

## Requirements
- R1: `sum_o` equals the sum over all operands of (+/-) the widened operand value, reduced modulo 2^OUT_W, for any combination of values, subtract flags and signed flags.
- R2: Overflow wraps silently. At OUT_W=8 with four operands, four values of 255 all added give 252, and 255+1+0+0 gives 0.
- R3: Setting bit k of `sub_i` subtracts operand k. At OUT_W=8, 1+1-255+1 gives 4, with operand 2 subtracted. 255-1-1-1 gives 252, with operands 1 to 3 subtracted.
- R4: With every bit of `sub_i` set, the result is the two's-complement negation of the plain sum. In the default instance, six operands of 1 give 1018, and all-ones operands give 758.
- R5: Setting bit k of `sgn_i` sign-extends operand k from its top active bit up to OUT_W. In the default instance, three operands of 0x80 give 640 when signed and 384 when unsigned.
- R6: A narrow slot uses only its low NARROW_W bits; its upper slot bits have no effect. In the default instance, slot 5 is 4 bits wide, so 0xF8 alone gives 8 when unsigned and 1016 when signed.
- R7: A nested difference c-(a-b) is formed as c - a + b and is exact modulo 2^OUT_W. At 8 bits, c=10, a=30, b=20 gives 0, and c=1, a=255, b=1 gives 3.
- R8: All-zero operands give a zero result for every setting of `sub_i` and `sgn_i`.
- R9: In the two-operand instance without subtraction support, the result is the sum of the two operands modulo 2^OUT_W. For example, 200+100 gives 44 at 8 bits.
- R10: When subtraction support is disabled, `sub_i` has no effect on `sum_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ops_i | input | N_OPS x SLOT_W | Packed operand slots, slot k in `ops_i[k]` |
| sub_i | input | N_OPS | Bit k set: operand k is subtracted |
| sgn_i | input | N_OPS | Bit k set: operand k is two's complement |
| sum_o | output | OUT_W | Wrapped result |

## Verification
The hardest case to reach from the ports is a correction word that carries into higher bits. This happens when several subtracted operands meet in the same column as sign-extended negative values. Random stimulus rarely lines up every subtract flag with large inverted values. So the bench forces masks with every flag set, combined with all-ones and 0x80 operands. It also drives the narrow slot with garbage in its upper bits, so any leakage of those bits shows up at the result. Three instances with different parameters exercise the row-free path, the wrapping path and the mixed-width path side by side. Each is compared every cycle against an integer model.

// File: rtl/csa_tree_pkg.sv
package csa_tree_pkg;

   localparam int MAX_OPS = 64;

   // number of 3:2 rows needed to bring vec_cnt vectors down to two
   function automatic int rows_for(input int vec_cnt);
      return (vec_cnt > 2) ? vec_cnt - 2 : 0;
   endfunction

   // total vector slots: inputs plus two outputs per row
   function automatic int slots_for(input int vec_cnt);
      return vec_cnt + 2 * rows_for(vec_cnt);
   endfunction

endpackage

// File: rtl/csa_operand_ext.sv
module csa_operand_ext #(
   parameter int SLOT_W = 8,
   parameter int ACT_W  = 8,
   parameter int OUT_W  = 10
) (
   input  logic [SLOT_W-1:0] raw_i,
   input  logic              sgn_i,
   input  logic              inv_i,
   output logic [OUT_W-1:0]  vec_o
);

   logic [OUT_W-1:0] widened;
   logic             fill_bit;

   assign fill_bit = sgn_i & raw_i[ACT_W-1];

   for (genvar b = 0; b < OUT_W; b++) begin : g_bit
      if (b < ACT_W) begin : g_data
         assign widened[b] = raw_i[b];
      end else begin : g_fill
         assign widened[b] = fill_bit;
      end
   end

   if (ACT_W < SLOT_W) begin : g_narrow
      logic [SLOT_W-ACT_W-1:0] raw_hi_unused;
      assign raw_hi_unused = raw_i[SLOT_W-1:ACT_W];
   end

   assign vec_o = inv_i ? ~widened : widened;

endmodule

// File: rtl/csa_compress_row.sv
module csa_compress_row #(
   parameter int W = 10
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic [W-1:0] c_i,
   output logic [W-1:0] sum_o,
   output logic [W-1:0] cry_o
);

   logic [W-1:0] maj;
   logic         maj_top_unused;

   assign sum_o          = a_i ^ b_i ^ c_i;
   assign maj            = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
   assign cry_o          = {maj[W-2:0], 1'b0};
   assign maj_top_unused = maj[W-1];

endmodule

// File: rtl/csa_cpa.sv
module csa_cpa #(
   parameter int W = 10
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   output logic [W-1:0] s_o
);

   assign s_o = x_i + y_i;

endmodule

// File: rtl/csa_tree_adder.sv
module csa_tree_adder
   import csa_tree_pkg::*;
#(
   parameter int          N_OPS      = 6,
   parameter int          SLOT_W     = 8,
   parameter int          OUT_W      = 10,
   parameter bit          SUB_EN     = 1'b1,
   parameter int          NARROW_W   = 4,
   parameter logic [63:0] NARROW_SEL = 64'h20
) (
   input  logic [N_OPS-1:0][SLOT_W-1:0] ops_i,
   input  logic [N_OPS-1:0]             sub_i,
   input  logic [N_OPS-1:0]             sgn_i,
   output logic [OUT_W-1:0]             sum_o
);

   localparam int NVEC  = N_OPS + (SUB_EN ? 1 : 0);
   localparam int NROWS = rows_for(NVEC);
   localparam int NALL  = slots_for(NVEC);

   // elaboration-time parameter checks
   if (N_OPS < 2 || N_OPS > MAX_OPS) begin : g_bad_nops
      $error("csa_tree_adder: N_OPS out of range");
   end
   if (OUT_W < 2 || SLOT_W > OUT_W) begin : g_bad_width
      $error("csa_tree_adder: SLOT_W must not exceed OUT_W, OUT_W >= 2");
   end
   if (NARROW_W < 1 || NARROW_W > SLOT_W) begin : g_bad_narrow
      $error("csa_tree_adder: NARROW_W must lie in 1..SLOT_W");
   end

   logic [OUT_W-1:0] vecs [NALL];

   // operand widening and inversion
   for (genvar k = 0; k < N_OPS; k++) begin : g_op
      localparam int AW = NARROW_SEL[k] ? NARROW_W : SLOT_W;
      logic inv;
      assign inv = SUB_EN ? sub_i[k] : 1'b0;
      csa_operand_ext #(
         .SLOT_W (SLOT_W),
         .ACT_W  (AW),
         .OUT_W  (OUT_W)
      ) u_ext (
         .raw_i (ops_i[k]),
         .sgn_i (sgn_i[k]),
         .inv_i (inv),
         .vec_o (vecs[k])
      );
   end

   // one correction word holds every +1 owed by inverted operands
   if (SUB_EN) begin : g_corr
      assign vecs[N_OPS] = OUT_W'($countones(sub_i));
   end

   // queue-ordered rows: row r eats slots 3r..3r+2, writes NVEC+2r, NVEC+2r+1
   for (genvar r = 0; r < NROWS; r++) begin : g_row
      csa_compress_row #(
         .W (OUT_W)
      ) u_row (
         .a_i   (vecs[3*r]),
         .b_i   (vecs[3*r+1]),
         .c_i   (vecs[3*r+2]),
         .sum_o (vecs[NVEC+2*r]),
         .cry_o (vecs[NVEC+2*r+1])
      );
   end

   csa_cpa #(
      .W (OUT_W)
   ) u_cpa (
      .x_i (vecs[NALL-2]),
      .y_i (vecs[NALL-1]),
      .s_o (sum_o)
   );

endmodule

// File: rtl/csa_tree_adder_chk.sv
module csa_tree_adder_chk #(
   parameter int          N_OPS      = 6,
   parameter int          SLOT_W     = 8,
   parameter int          OUT_W      = 10,
   parameter bit          SUB_EN     = 1'b1,
   parameter int          NARROW_W   = 4,
   parameter logic [63:0] NARROW_SEL = 64'h20
) (
   input logic [N_OPS-1:0][SLOT_W-1:0] ops_i,
   input logic [N_OPS-1:0]             sub_i,
   input logic [N_OPS-1:0]             sgn_i,
   input logic [OUT_W-1:0]             sum_i
);

   logic [OUT_W-1:0] model_sum;
   logic [OUT_W-1:0] lone_val;
   logic             lone_sub;
   logic             lone_sgn;
   int               nz_cnt;

   always_comb begin
      model_sum = '0;
      lone_val  = '0;
      lone_sub  = 1'b0;
      lone_sgn  = 1'b0;
      nz_cnt    = 0;
      for (int k = 0; k < N_OPS; k++) begin
         int               w;
         logic [OUT_W-1:0] v;
         w = NARROW_SEL[k] ? NARROW_W : SLOT_W;
         v = '0;
         for (int b = 0; b < OUT_W; b++) begin
            if (b < w) v[b] = ops_i[k][b];
            else       v[b] = sgn_i[k] & ops_i[k][w-1];
         end
         if (SUB_EN && sub_i[k]) model_sum = model_sum - v;
         else                    model_sum = model_sum + v;
         if (v != '0) begin
            nz_cnt   = nz_cnt + 1;
            lone_val = v;
            lone_sub = SUB_EN && sub_i[k];
            lone_sgn = sgn_i[k];
         end
      end
   end

   always_comb begin
      if (!$isunknown({ops_i, sub_i, sgn_i})) begin
         // R1: result tracks the modular signed/unsigned sum
         assert_sum_model_R1: assert (sum_i == model_sum)
            else $error("sum %0d differs from model %0d", sum_i, model_sum);
         // R8: nothing in, nothing out, whatever the flags
         assert_zero_in_zero_out_R8: assert (nz_cnt != 0 || sum_i == '0)
            else $error("zero operands gave %0d", sum_i);
         // R3: a lone subtracted operand cancels against the result
         assert_lone_sub_cancels_R3: assert (!(nz_cnt == 1 && lone_sub) || OUT_W'(sum_i + lone_val) == '0)
            else $error("lone subtract left %0d", sum_i);
         // R6: a lone added unsigned operand appears unchanged
         assert_lone_add_passes_R6: assert (!(nz_cnt == 1 && !lone_sub && !lone_sgn) || sum_i == lone_val)
            else $error("lone add gave %0d", sum_i);
      end
   end

endmodule

bind csa_tree_adder csa_tree_adder_chk #(
   .N_OPS      (N_OPS),
   .SLOT_W     (SLOT_W),
   .OUT_W      (OUT_W),
   .SUB_EN     (SUB_EN),
   .NARROW_W   (NARROW_W),
   .NARROW_SEL (NARROW_SEL)
) u_chk (
   .ops_i (ops_i),
   .sub_i (sub_i),
   .sgn_i (sgn_i),
   .sum_i (sum_o)
);

// File: tb/tb_csa_tree_adder.sv
module tb_csa_tree_adder;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   int total_cnt = 0;
   int fail_cnt  = 0;
   bit finished  = 1'b0;

   // default instance: 6 operands, 8-bit slots, 10-bit result, slot 5 narrow
   logic [5:0][7:0] m_ops;
   logic [5:0]      m_sub, m_sgn;
   logic [9:0]      m_sum;
   // 4 operands, 8-bit result
   logic [3:0][7:0] w_ops;
   logic [3:0]      w_sub, w_sgn;
   logic [7:0]      w_sum;
   // 2 operands, no subtraction support
   logic [1:0][7:0] p_ops;
   logic [1:0]      p_sub, p_sgn;
   logic [7:0]      p_sum;

   csa_tree_adder #(.N_OPS(6), .SLOT_W(8), .OUT_W(10), .SUB_EN(1'b1),
                    .NARROW_W(4), .NARROW_SEL(64'h20))
   dut (.ops_i(m_ops), .sub_i(m_sub), .sgn_i(m_sgn), .sum_o(m_sum));

   csa_tree_adder #(.N_OPS(4), .SLOT_W(8), .OUT_W(8), .SUB_EN(1'b1),
                    .NARROW_W(4), .NARROW_SEL(64'h0))
   dut_w8 (.ops_i(w_ops), .sub_i(w_sub), .sgn_i(w_sgn), .sum_o(w_sum));

   csa_tree_adder #(.N_OPS(2), .SLOT_W(8), .OUT_W(8), .SUB_EN(1'b0),
                    .NARROW_W(4), .NARROW_SEL(64'h0))
   dut_pair (.ops_i(p_ops), .sub_i(p_sub), .sgn_i(p_sgn), .sum_o(p_sum));

   function automatic int ref_sum(input int n, input int outw, input int slotw,
                                  input logic [63:0] nsel, input int nw, input bit suben,
                                  input logic [7:0][7:0] ops, input logic [7:0] sub,
                                  input logic [7:0] sgn);
      longint acc = 0;
      for (int k = 0; k < n; k++) begin
         int     w;
         longint v;
         w = nsel[k] ? nw : slotw;
         v = longint'(ops[k]) & ((longint'(1) << w) - 1);
         if (sgn[k] && (((v >> (w - 1)) & 1) == 1)) v = v - (longint'(1) << w);
         if (suben && sub[k]) acc = acc - v;
         else                 acc = acc + v;
      end
      return int'(acc & ((longint'(1) << outw) - 1));
   endfunction

   task automatic check(input string req, input int act, input int exp);
      total_cnt++;
      if (act != exp) begin
         fail_cnt++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic compare_all(input string req);
      check({req, " main"}, int'(m_sum),
            ref_sum(6, 10, 8, 64'h20, 4, 1'b1, {16'h0, m_ops}, {2'b0, m_sub}, {2'b0, m_sgn}));
      check({req, " w8"}, int'(w_sum),
            ref_sum(4, 8, 8, 64'h0, 4, 1'b1, {32'h0, w_ops}, {4'b0, w_sub}, {4'b0, w_sgn}));
      check({req, " pair"}, int'(p_sum),
            ref_sum(2, 8, 8, 64'h0, 4, 1'b0, {48'h0, p_ops}, {6'b0, p_sub}, {6'b0, p_sgn}));
   endtask

   task automatic zero_all();
      m_ops = '0; m_sub = '0; m_sgn = '0;
      w_ops = '0; w_sub = '0; w_sgn = '0;
      p_ops = '0; p_sub = '0; p_sgn = '0;
   endtask

   task automatic report();
      finished = 1'b1;
      $display("%0d/%0d checks passed", total_cnt - fail_cnt, total_cnt);
      $finish;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total_cnt++;
         fail_cnt++;
         $display("FAIL R1 watchdog: actual=timeout expected=completion");
         report();
      end
   end

   initial begin : stim
      zero_all();
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R8: reset-time inputs are zero, every result is zero
      check("R8 reset main", int'(m_sum), 0);
      check("R8 reset w8",   int'(w_sum), 0);
      check("R8 reset pair", int'(p_sum), 0);
      rst_n = 1'b1;

      // R2: wrap at 8 bits
      @(posedge clk); zero_all();
      w_ops = {8'd255, 8'd255, 8'd255, 8'd255};
      @(negedge clk); check("R2 four 255", int'(w_sum), 252); compare_all("R2");
      @(posedge clk); w_ops = {8'd0, 8'd0, 8'd1, 8'd255};
      @(negedge clk); check("R2 255+1", int'(w_sum), 0);

      // R3: mixed subtract at 8 bits (operand k in w_ops[k])
      @(posedge clk); w_ops = {8'd1, 8'd255, 8'd1, 8'd1}; w_sub = 4'b0100;
      @(negedge clk); check("R3 1+1-255+1", int'(w_sum), 4);
      @(posedge clk); w_ops = {8'd1, 8'd1, 8'd1, 8'd255}; w_sub = 4'b1110;
      @(negedge clk); check("R3 255-1-1-1", int'(w_sum), 252); compare_all("R3");

      // R7: c-(a-b) as c - a + b; slot0=c, slot1=a subtracted, slot2=b
      @(posedge clk); w_ops = {8'd0, 8'd20, 8'd30, 8'd10}; w_sub = 4'b0010;
      @(negedge clk); check("R7 30,20,10", int'(w_sum), 0);
      @(posedge clk); w_ops = {8'd0, 8'd1, 8'd255, 8'd1};
      @(negedge clk); check("R7 255,1,1", int'(w_sum), 3);
      @(posedge clk); w_ops = {8'd0, 8'd25, 8'd50, 8'd100};
      @(negedge clk); check("R7 50,25,100", int'(w_sum), 75);

      // R4: every operand subtracted
      @(posedge clk); zero_all();
      m_ops = {6{8'd1}}; m_sub = 6'h3F;
      @(negedge clk); check("R4 all-sub ones", int'(m_sum), 1018);
      @(posedge clk); m_ops = {6{8'hFF}};
      @(negedge clk); check("R4 all-sub all-ones", int'(m_sum), 758); compare_all("R4");

      // R1: all-ones added, unsigned then signed
      @(posedge clk); m_sub = '0; m_sgn = '0;
      @(negedge clk); check("R1 all-ones add", int'(m_sum), 266);
      @(posedge clk); m_sgn = 6'h3F;
      @(negedge clk); check("R1 all-ones signed", int'(m_sum), 1018);

      // R5: sign extension from 8 to 10 bits
      @(posedge clk); zero_all(); m_ops[0] = 8'h80; m_ops[1] = 8'h80; m_ops[2] = 8'h80;
      @(negedge clk); check("R5 unsigned 0x80", int'(m_sum), 384);
      @(posedge clk); m_sgn = 6'h07;
      @(negedge clk); check("R5 signed 0x80", int'(m_sum), 640);

      // R6: narrow slot 5 keeps only 4 bits
      @(posedge clk); zero_all(); m_ops[5] = 8'hF8;
      @(negedge clk); check("R6 narrow unsigned", int'(m_sum), 8);
      @(posedge clk); m_sgn = 6'h20;
      @(negedge clk); check("R6 narrow signed", int'(m_sum), 1016);

      // R8: zero operands with all flags set
      @(posedge clk); zero_all(); m_sub = 6'h3F; m_sgn = 6'h3F; w_sub = 4'hF; w_sgn = 4'hF;
      @(negedge clk); check("R8 zero all-flags main", int'(m_sum), 0);
      check("R8 zero all-flags w8", int'(w_sum), 0);

      // R9 / R10: two-operand adder, subtract flags ignored
      @(posedge clk); zero_all(); p_ops = {8'd100, 8'd200};
      @(negedge clk); check("R9 200+100", int'(p_sum), 44);
      @(posedge clk); p_sub = 2'b11;
      @(negedge clk); check("R10 sub flags ignored", int'(p_sum), 44);

      // R1: random vectors, compared on every clock
      for (int i = 0; i < 400; i++) begin
         @(posedge clk);
         m_ops = {$urandom, $urandom}; m_sub = 6'($urandom); m_sgn = 6'($urandom);
         w_ops = $urandom;             w_sub = 4'($urandom); w_sgn = 4'($urandom);
         p_ops = 16'($urandom);        p_sub = 2'($urandom); p_sgn = 2'($urandom);
         if (i % 7 == 0) m_sub = 6'h3F;
         if (i % 11 == 0) begin m_ops = {6{8'hFF}}; m_sgn = 6'h3F; end
         @(negedge clk);
         compare_all("R1 random");
      end

      report();
   end

endmodule